// File: doc/BRIEF.md
# Two-Flag Mailbox Semaphore

This block grants exclusive use of one shared resource to one of two requesters, a host side and a local side. It does this without a central arbiter. Each side owns a single flag register, and only that side's sequencer writes it. Both flags can be read on the ports.

A side that wants the resource first looks at the other side's flag. If that flag is set, the side waits for a fixed number of cycles and looks again. If the flag is clear, the side raises its own flag and then looks at the other flag a second time. If both flags are set at that point, each side clears its own flag and waits. If the second look finds the other flag still clear, the side wins.

The winning side's grant stays high until its user pulses release. On that pulse the side drops its flag. The two sides use different waiting times, so a tie between them cannot repeat forever.

Top module: `mbox_sema`

## Requirements
- R1: After reset, both grants are low and both flags are clear.
- R2: With the other flag clear, a request first sampled at clock edge e0 sets the own flag after edge e1 and raises the grant after edge e2.
- R3: If a side finds the other flag set at its first look, it never sets its own flag and never grants while the other side holds its grant.
- R4: When both sides set their flags on the same edge, both flags are clear after the next edge, and neither side is granted.
- R5: Each side waits a parameterised number of cycles after backing off (HOST_BACKOFF, LOCAL_BACKOFF). After a simultaneous start, the side with the shorter wait is granted after edge 2+HOST_BACKOFF+2, counted from e0, and the other side is not granted.
- R6: A grant stays high while release is low. A release pulse seen during a grant clears both the grant and the own flag on that edge.
- R7: The two grants are never high in the same cycle.
- R8: While a side's grant is high, its own flag is set.
- R9: If the request drops after the own flag is set but before the grant, the flag is cleared after the next edge and no grant appears.
- R10: A side that keeps requesting while the other holds the grant is granted within its backoff plus four cycles after the other side releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host side request, level, held until the grant or withdrawn |
| host_rel_i | input | 1 | Host side release pulse, used during the grant |
| host_gnt_o | output | 1 | Host side grant |
| local_req_i | input | 1 | Local side request, level |
| local_rel_i | input | 1 | Local side release pulse |
| local_gnt_o | output | 1 | Local side grant |
| host_flag_o | output | 1 | Host side flag register, readable |
| local_flag_o | output | 1 | Local side flag register, readable |

## Verification
The hardest case to reach is a true collision. Both sides must pass their first look on the same edge, so both flags rise together, and then both must back off. Random traffic seldom lines up on that exact edge.

A directed case therefore raises both requests on the same cycle. It checks that both flags are set and then cleared, and it checks the exact edge on which the side with the shorter wait wins. The same case also covers the path where a request is withdrawn between the claim and the second look.

Random request and hold patterns then cover the staggered orderings, in which one side's claim lands one cycle before or after the other side's look.

// File: rtl/mbox_sema_pkg.sv
package mbox_sema_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_VERIFY,
    ST_GRANT,
    ST_BACKOFF
  } side_st_e;
endpackage

// File: rtl/mbox_flag_reg.sv
module mbox_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/mbox_side_seq.sv
module mbox_side_seq
  import mbox_sema_pkg::*;
#(
  parameter int unsigned BACKOFF = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic rel_i,
  input  logic opp_flag_i,
  output logic set_o,
  output logic clr_o,
  output logic gnt_o
);
  localparam int unsigned CNT_W = (BACKOFF < 2) ? 1 : $clog2(BACKOFF + 1);

  side_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic cnt_done;

  assign cnt_done = (cnt_q == CNT_W'(BACKOFF - 1));
  assign gnt_o    = (st_q == ST_GRANT);

  always_comb begin
    st_d  = st_q;
    set_o = 1'b0;
    clr_o = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (req_i) st_d = ST_CHECK;
      ST_CHECK: begin
        if (!req_i)          st_d = ST_IDLE;
        else if (opp_flag_i) st_d = ST_BACKOFF;
        else begin
          set_o = 1'b1;
          st_d  = ST_VERIFY;
        end
      end
      ST_VERIFY: begin
        // own flag is now visible; second look at the other side
        if (!req_i) begin
          clr_o = 1'b1;
          st_d  = ST_IDLE;
        end else if (opp_flag_i) begin
          clr_o = 1'b1;
          st_d  = ST_BACKOFF;
        end else begin
          st_d = ST_GRANT;
        end
      end
      ST_GRANT: if (rel_i) begin
        clr_o = 1'b1;
        st_d  = ST_IDLE;
      end
      ST_BACKOFF: begin
        if (!req_i)        st_d = ST_IDLE;
        else if (cnt_done) st_d = ST_CHECK;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_q == ST_BACKOFF) ? cnt_q + 1'b1 : '0;
    end
  end
endmodule

// File: rtl/mbox_sema.sv
module mbox_sema #(
  parameter int unsigned HOST_BACKOFF  = 3,
  parameter int unsigned LOCAL_BACKOFF = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_req_i,
  input  logic host_rel_i,
  output logic host_gnt_o,
  input  logic local_req_i,
  input  logic local_rel_i,
  output logic local_gnt_o,
  output logic host_flag_o,
  output logic local_flag_o
);
  localparam int unsigned N_SIDES = 2;

  logic [N_SIDES-1:0] req, rel, gnt, flag, set, clr;

  assign req = {local_req_i, host_req_i};
  assign rel = {local_rel_i, host_rel_i};

  for (genvar i = 0; i < N_SIDES; i++) begin : g_side
    localparam int unsigned BO = (i == 0) ? HOST_BACKOFF : LOCAL_BACKOFF;

    mbox_side_seq #(.BACKOFF(BO)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req[i]),
      .rel_i      (rel[i]),
      .opp_flag_i (flag[N_SIDES-1-i]),
      .set_o      (set[i]),
      .clr_o      (clr[i]),
      .gnt_o      (gnt[i])
    );

    mbox_flag_reg u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set[i]),
      .clr_i  (clr[i]),
      .flag_o (flag[i])
    );
  end

  assign host_gnt_o   = gnt[0];
  assign local_gnt_o  = gnt[1];
  assign host_flag_o  = flag[0];
  assign local_flag_o = flag[1];
endmodule

// File: rtl/mbox_sema_chk.sv
module mbox_sema_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic host_rel_i,
  input logic local_rel_i,
  input logic host_gnt_o,
  input logic local_gnt_o,
  input logic host_flag_o,
  input logic local_flag_o
);
  assert_mutex_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_gnt_o && local_gnt_o));

  assert_host_gnt_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o |-> host_flag_o);

  assert_local_gnt_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_gnt_o |-> local_flag_o);

  assert_host_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o && !host_rel_i |=> host_gnt_o);

  assert_local_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_gnt_o && !local_rel_i |=> local_gnt_o);

  assert_host_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o && host_rel_i |=> !host_gnt_o && !host_flag_o);

  assert_local_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_gnt_o && local_rel_i |=> !local_gnt_o && !local_flag_o);

  assert_collide_backoff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_flag_o) && $rose(local_flag_o) |=> !host_flag_o && !local_flag_o);
endmodule

bind mbox_sema mbox_sema_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_rel_i   (host_rel_i),
  .local_rel_i  (local_rel_i),
  .host_gnt_o   (host_gnt_o),
  .local_gnt_o  (local_gnt_o),
  .host_flag_o  (host_flag_o),
  .local_flag_o (local_flag_o)
);

// File: tb/sim_mbox_sema.sv
`timescale 1ns/1ps
module sim_mbox_sema;
  localparam int unsigned HB = 3;
  localparam int unsigned LB = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_req = 0, h_rel = 0, l_req = 0, l_rel = 0;
  logic h_gnt, l_gnt, h_flag, l_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbox_sema #(.HOST_BACKOFF(HB), .LOCAL_BACKOFF(LB)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(h_req), .host_rel_i(h_rel), .host_gnt_o(h_gnt),
    .local_req_i(l_req), .local_rel_i(l_rel), .local_gnt_o(l_gnt),
    .host_flag_o(h_flag), .local_flag_o(l_flag)
  );

  function automatic int win_edge(int unsigned bo);
    return 2 + bo + 2;
  endfunction

  function automatic int wait_bound(int unsigned bo);
    return bo + 4;
  endfunction

  task automatic check(bit ok, string rq, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    bit h_prev_gnt, l_prev_gnt, h_prev_rel, l_prev_rel;
    int h_mode, l_mode, h_hold, l_hold, h_wins, l_wins;
    void'($urandom(32'd7719));
    @(negedge clk);
    check(!h_gnt && !l_gnt && !h_flag && !l_flag, "R1 reset", {h_gnt, l_gnt, h_flag, l_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 uncontended
    h_req = 1;
    edges(2);
    check(h_flag && !h_gnt, "R2 flag after e1", {h_flag, h_gnt}, 2);
    edges(1);
    check(h_gnt, "R2 grant after e2", h_gnt, 1);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin edges(1); cnt += h_gnt; end
    check(cnt == 4, "R6 grant held", cnt, 4);
    h_rel = 1; h_req = 0;
    edges(1);
    h_rel = 0;
    check(!h_gnt && !h_flag, "R6 release clears", {h_gnt, h_flag}, 0);
    edges(2);

    // R4/R5 collision
    h_req = 1; l_req = 1;
    edges(2);
    check(h_flag && l_flag, "R4 both claim", {h_flag, l_flag}, 3);
    edges(1);
    check(!h_flag && !l_flag && !h_gnt && !l_gnt, "R4 both back off",
          {h_flag, l_flag, h_gnt, l_gnt}, 0);
    edges(win_edge(HB) - 1 - 2);
    check(!h_gnt, "R5 host not yet granted", h_gnt, 0);
    edges(1);
    check(h_gnt && !l_gnt, "R5 host wins at 2+HB+2", {h_gnt, l_gnt}, 2);

    // R10 local waits, then host releases
    edges(3);
    h_rel = 1; h_req = 0;
    edges(1);
    h_rel = 0;
    cnt = 0;
    while (!l_gnt && cnt < 40) begin edges(1); cnt++; end
    check(l_gnt && cnt <= wait_bound(LB), "R10 local granted after release", cnt, wait_bound(LB));

    // R3 host finds local flag set
    h_req = 1;
    cnt = 0;
    for (int k = 0; k < 12; k++) begin edges(1); cnt += h_flag + h_gnt; end
    check(cnt == 0, "R3 no claim while other holds", cnt, 0);
    l_rel = 1; l_req = 0;
    edges(1);
    l_rel = 0;
    cnt = 0;
    while (!h_gnt && cnt < 40) begin edges(1); cnt++; end
    check(h_gnt && cnt <= wait_bound(HB), "R10 host granted after release", cnt, wait_bound(HB));
    h_rel = 1; h_req = 0;
    edges(1);
    h_rel = 0;
    edges(2);

    // R9 withdraw between claim and grant
    l_req = 1;
    edges(2);
    check(l_flag, "R9 claimed", l_flag, 1);
    l_req = 0;
    edges(1);
    check(!l_flag && !l_gnt, "R9 withdraw clears flag", {l_flag, l_gnt}, 0);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin edges(1); cnt += l_gnt + l_flag; end
    check(cnt == 0, "R9 stays idle", cnt, 0);

    // random traffic: R6 R7 R8
    h_mode = 0; l_mode = 0; h_hold = 0; l_hold = 0; h_wins = 0; l_wins = 0;
    h_prev_gnt = 0; l_prev_gnt = 0; h_prev_rel = 0; l_prev_rel = 0;
    for (int c = 0; c < 4000; c++) begin
      edges(1);
      check(!(h_gnt && l_gnt), "R7 mutual exclusion", {h_gnt, l_gnt}, 0);
      if (h_gnt) check(h_flag, "R8 host flag with grant", h_flag, 1);
      if (l_gnt) check(l_flag, "R8 local flag with grant", l_flag, 1);
      if (h_prev_gnt) check(h_gnt == !h_prev_rel, "R6 host hold/release", h_gnt, !h_prev_rel);
      if (l_prev_gnt) check(l_gnt == !l_prev_rel, "R6 local hold/release", l_gnt, !l_prev_rel);
      h_prev_gnt = h_gnt; l_prev_gnt = l_gnt;
      h_rel = 0; l_rel = 0;
      // host driver: 0 idle, 1 waiting, 2 holding
      if (h_mode == 0 && ($urandom % 4) == 0) begin h_req = 1; h_mode = 1; end
      else if (h_mode == 1 && h_gnt) begin h_mode = 2; h_hold = $urandom % 6; h_wins++; end
      else if (h_mode == 1 && ($urandom % 64) == 0) begin h_req = 0; h_mode = 0; end
      else if (h_mode == 2) begin
        if (h_hold == 0) begin h_rel = 1; h_req = 0; h_mode = 0; end
        else h_hold--;
      end
      if (l_mode == 0 && ($urandom % 4) == 0) begin l_req = 1; l_mode = 1; end
      else if (l_mode == 1 && l_gnt) begin l_mode = 2; l_hold = $urandom % 6; l_wins++; end
      else if (l_mode == 1 && ($urandom % 64) == 0) begin l_req = 0; l_mode = 0; end
      else if (l_mode == 2) begin
        if (l_hold == 0) begin l_rel = 1; l_req = 0; l_mode = 0; end
        else l_hold--;
      end
      h_prev_rel = h_rel; l_prev_rel = l_rel;
    end
    check(h_wins > 0 && l_wins > 0, "R10 both sides served", h_wins * l_wins, 1);
    done = 1;
    summary();
    $finish;
  end
endmodule